// File: doc/BRIEF.md
# Single-Slot Handshake Mailbox

This block carries one data word from a producer, such as an end-of-conversion path of a converter, to a consumer, such as a processor read port. The word sits in a single storage slot. A posted flag tells the consumer that the slot holds a word it has not yet taken. The producer offers a word with a one-cycle strobe, and the consumer takes the word with its own strobe. Taking the word clears the flag, and this is how the producer learns that the word was collected.

A 2-bit mode field selects how the producer is treated:

- **Hold mode** keeps an unread word and refuses newer ones.
- **Replace mode** always overwrites the slot.
- **Request mode** lets a word in only after the consumer has asked for one.

An attempt that meets an unread word is an overload. It is latched in a sticky indicator until it is cleared. The data word and the flag change together on one clock edge, so a word shown as posted is never half old and half new.

Top module: `mbox_slot`

## Requirements
- R1: After reset, `slot_data` is 0 and `posted`, `req_pending` and `ovl_flag` are all 0.
- R2: In hold mode (`mode_sel` 00, and also 11), an offer made while `posted` is 0 is accepted. `prod_accept` is 1 in that cycle, and after the next edge `slot_data` holds the offered word and `posted` is 1.
- R3: In hold mode, an offer made while `posted` is 1 and `cons_take` is 0 is refused. `prod_accept` is 0, and `slot_data` is unchanged after the edge.
- R4: An overload occurs when an offer finds `posted` at 1 with no `cons_take` in the same cycle. In request mode this applies only when a request is pending. After an overload, `ovl_flag` is 1 following the next edge. This holds in every mode.
- R5: `ovl_flag` stays 1 until a cycle with `ovl_clear` at 1 and no new overload. If an overload and `ovl_clear` fall in the same cycle, the flag stays 1.
- R6: In replace mode (`mode_sel` 01), every offer is accepted. After the edge the slot holds the new word and `posted` is 1.
- R7: A `cons_take` with no accepted offer in the same cycle clears `posted` after the edge, and `slot_data` is left as it was.
- R8: When `cons_take` and an accepted offer fall in the same cycle, `slot_data` shows the old word during that cycle. After the edge it shows the new word, and `posted` is 1.
- R9: In request mode (`mode_sel` 10), an offer made while `req_pending` is 0 is ignored. `prod_accept` is 0, and `slot_data` and `posted` are unchanged.
- R10: In request mode, `cons_req` sets `req_pending`. An offer made while a request is pending is accepted, sets `posted`, and clears `req_pending`.
- R11: In a cycle where `mode_sel` differs from its value in the previous cycle, no offer is accepted, and after the edge `posted` and `req_pending` are 0. `slot_data` keeps its value.
- R12: `slot_data` changes only after a cycle in which `prod_accept` was 1, and then all bits change at once to the offered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Producer policy: 00 hold, 01 replace, 10 request, 11 hold |
| prod_valid | input | 1 | Producer offers `prod_data` this cycle |
| prod_data | input | DATA_W | Offered word |
| cons_take | input | 1 | Consumer collects `slot_data` this cycle |
| cons_req | input | 1 | Consumer asks for a fresh word (request mode) |
| ovl_clear | input | 1 | Clears the sticky overload indicator |
| slot_data | output | DATA_W | Word held in the slot |
| posted | output | 1 | Slot holds an untaken word |
| req_pending | output | 1 | A consumer request awaits a word |
| ovl_flag | output | 1 | Sticky overload indicator |
| prod_accept | output | 1 | The offer in this cycle is being stored |

## Verification
The bench builds the block with `DATA_W` at its default of 16. The random words therefore often differ in both bytes between one offer and the next, and any split or partial update of the slot shows up as a mismatch. Random mode switches let a flush land on a pending request, an unread word or an overload in the same cycle. Random take and clear strobes often coincide with offers, which covers the same-cycle orderings named in R5 and R8.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    POL_HOLD    = 2'b00,
    POL_REPLACE = 2'b01,
    POL_REQUEST = 2'b10,
    POL_SPARE   = 2'b11
  } pol_e;

  // The spare encoding behaves as hold.
  function automatic pol_e pol_decode(input logic [1:0] f);
    pol_e p;
    p = (f == 2'b11) ? POL_HOLD : pol_e'(f);
    return p;
  endfunction

  // Whether the slot would take an offered word under a given policy.
  function automatic logic slot_accepts(input pol_e p, input logic is_posted,
                                        input logic req, input logic take);
    logic ok;
    case (p)
      POL_REPLACE: ok = 1'b1;
      POL_REQUEST: ok = req;
      default:     ok = !is_posted || take;
    endcase
    return ok;
  endfunction

  // An offer that meets an untaken word is an overload.
  function automatic logic clobbers(input pol_e p, input logic valid,
                                    input logic is_posted, input logic req,
                                    input logic take);
    return valid && is_posted && !take && ((p != POL_REQUEST) || req);
  endfunction

endpackage

// File: rtl/mbox_policy.sv
module mbox_policy
  import mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       prod_valid,
  input  logic       is_posted,
  input  logic       req_q,
  input  logic       take,
  output pol_e       pol,
  output logic       mode_chg,
  output logic       wr_fire,
  output logic       ovl_event
);
  logic [1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 2'b00;
    else        mode_q <= mode_sel;
  end

  always_comb begin
    mode_chg  = (mode_sel != mode_q);
    pol       = pol_decode(mode_sel);
    wr_fire   = prod_valid && !mode_chg && slot_accepts(pol, is_posted, req_q, take);
    ovl_event = !mode_chg && clobbers(pol, prod_valid, is_posted, req_q, take);
  end
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              take,
  output logic [DATA_W-1:0] word_q,
  output logic              posted_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      posted_q <= 1'b0;
    end else if (flush) begin
      posted_q <= 1'b0;
    end else if (wr_fire) begin
      word_q   <= wr_word;
      posted_q <= 1'b1;
    end else if (take) begin
      posted_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_req.sv
module mbox_req (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic arm,
  input  logic done,
  output logic req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     req_q <= 1'b0;
    else if (flush) req_q <= 1'b0;
    else if (arm)   req_q <= 1'b1;
    else if (done)  req_q <= 1'b0;
  end
endmodule

// File: rtl/mbox_ovl.sv
module mbox_ovl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
  import mbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              prod_valid,
  input  logic [DATA_W-1:0] prod_data,
  input  logic              cons_take,
  input  logic              cons_req,
  input  logic              ovl_clear,
  output logic [DATA_W-1:0] slot_data,
  output logic              posted,
  output logic              req_pending,
  output logic              ovl_flag,
  output logic              prod_accept
);
  pol_e pol;
  logic mode_chg;
  logic wr_fire;
  logic ovl_event;
  logic req_arm;
  logic req_done;

  mbox_policy u_policy (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .prod_valid(prod_valid),
    .is_posted(posted), .req_q(req_pending), .take(cons_take),
    .pol(pol), .mode_chg(mode_chg), .wr_fire(wr_fire), .ovl_event(ovl_event)
  );

  mbox_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(mode_chg), .wr_fire(wr_fire),
    .wr_word(prod_data), .take(cons_take), .word_q(slot_data), .posted_q(posted)
  );

  assign req_arm  = cons_req && !mode_chg && (pol == POL_REQUEST);
  assign req_done = wr_fire && (pol == POL_REQUEST);

  mbox_req u_req (
    .clk(clk), .rst_n(rst_n), .flush(mode_chg), .arm(req_arm),
    .done(req_done), .req_q(req_pending)
  );

  mbox_ovl u_ovl (
    .clk(clk), .rst_n(rst_n), .set(ovl_event), .clr(ovl_clear), .flag_q(ovl_flag)
  );

  assign prod_accept = wr_fire;
endmodule

// File: rtl/mbox_slot_chk.sv
module mbox_slot_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prod_valid,
  input logic [DATA_W-1:0] prod_data,
  input logic              cons_take,
  input logic              cons_req,
  input logic              ovl_clear,
  input logic [DATA_W-1:0] slot_data,
  input logic              posted,
  input logic              req_pending,
  input logic              ovl_flag,
  input pol_e              pol,
  input logic              mode_chg,
  input logic              wr_fire,
  input logic              ovl_event
);
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_HOLD && !mode_chg && prod_valid && posted && !cons_take) |=> $stable(slot_data)); // R3
  AST_OVL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_event |=> ovl_flag); // R4
  AST_OVL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_flag && !ovl_clear) |=> ovl_flag); // R5
  AST_WRITE_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (posted && slot_data == $past(prod_data))); // R8
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (posted && cons_take && !wr_fire && !mode_chg) |=> !posted); // R7
  AST_REQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_REQUEST && !req_pending) |-> !wr_fire); // R9
  AST_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && pol == POL_REQUEST && !cons_req) |=> !req_pending); // R10
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!posted && !req_pending)); // R11
  AST_WORD_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(slot_data)); // R12
endmodule

bind mbox_slot mbox_slot_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_data(prod_data),
  .cons_take(cons_take), .cons_req(cons_req), .ovl_clear(ovl_clear),
  .slot_data(slot_data), .posted(posted), .req_pending(req_pending),
  .ovl_flag(ovl_flag), .pol(pol), .mode_chg(mode_chg), .wr_fire(wr_fire),
  .ovl_event(ovl_event)
);

// File: tb/mbox_slot_bench.sv
`timescale 1ns/1ps
module mbox_slot_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode_sel = 2'b00;
  logic         prod_valid = 1'b0;
  logic [W-1:0] prod_data = '0;
  logic         cons_take = 1'b0;
  logic         cons_req = 1'b0;
  logic         ovl_clear = 1'b0;
  logic [W-1:0] slot_data;
  logic         posted, req_pending, ovl_flag, prod_accept;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbox_slot #(.DATA_W(W)) u_mbox_slot (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .prod_valid(prod_valid),
    .prod_data(prod_data), .cons_take(cons_take), .cons_req(cons_req),
    .ovl_clear(ovl_clear), .slot_data(slot_data), .posted(posted),
    .req_pending(req_pending), .ovl_flag(ovl_flag), .prod_accept(prod_accept)
  );

  // Reference state kept from the requirements
  logic [W-1:0] m_data = '0;
  logic         m_posted = 0, m_req = 0, m_ovl = 0;
  logic [1:0]   m_mode = 2'b00;
  string        prev_tag = "R1";

  function automatic int eff_mode(input logic [1:0] m);
    return (m == 2'b11) ? 0 : int'(m);
  endfunction

  function automatic logic exp_accept(input logic [1:0] mv, input logic pv, input logic tk);
    if (mv != m_mode || !pv) return 1'b0;
    case (eff_mode(mv))
      1:       return 1'b1;
      2:       return m_req;
      default: return !m_posted || tk;
    endcase
  endfunction

  function automatic logic exp_overload(input logic [1:0] mv, input logic pv, input logic tk);
    if (mv != m_mode) return 1'b0;
    if (eff_mode(mv) == 2 && !m_req) return 1'b0;
    return pv && m_posted && !tk;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [1:0] mv, input logic pv, input logic [W-1:0] pd,
                     input logic tk, input logic rq, input logic oc, input string tag);
    logic acc, ov;
    @(negedge clk);
    chk(prev_tag, "slot_data", 32'(slot_data), 32'(m_data));
    chk(prev_tag, "posted", 32'(posted), 32'(m_posted));
    chk(prev_tag, "req_pending", 32'(req_pending), 32'(m_req));
    chk(prev_tag, "ovl_flag", 32'(ovl_flag), 32'(m_ovl));
    mode_sel = mv; prod_valid = pv; prod_data = pd;
    cons_take = tk; cons_req = rq; ovl_clear = oc;
    #1;
    acc = exp_accept(mv, pv, tk);
    ov  = exp_overload(mv, pv, tk);
    chk(tag, "prod_accept", 32'(prod_accept), 32'(acc));
    if (mv != m_mode) begin
      m_posted = 0; m_req = 0;
    end else begin
      if (acc) begin m_data = pd; m_posted = 1; end
      else if (tk) m_posted = 0;
      if (eff_mode(mv) == 2) m_req = rq ? 1'b1 : (acc ? 1'b0 : m_req);
    end
    m_ovl = ov ? 1'b1 : (oc ? 1'b0 : m_ovl);
    m_mode = mv;
    prev_tag = tag;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, seen at the first compare
    cyc(2'b00, 0, '0, 0, 0, 0, "R1");
    // R2 hold mode accepts into an empty slot
    cyc(2'b00, 1, 16'hA5C3, 0, 0, 0, "R2");
    // R3 refused while posted; also an overload
    cyc(2'b00, 1, 16'h1234, 0, 0, 0, "R3");
    cyc(2'b00, 0, '0, 0, 0, 0, "R4");
    // R5 sticky, then clear racing a new overload keeps it set
    cyc(2'b00, 0, '0, 0, 0, 0, "R5");
    cyc(2'b00, 1, 16'h0F0F, 0, 0, 1, "R5");
    cyc(2'b00, 0, '0, 0, 0, 1, "R5");
    // R7 take empties the slot, word kept
    cyc(2'b00, 0, '0, 1, 0, 0, "R7");
    // R8 take and write together
    cyc(2'b00, 1, 16'h00FF, 0, 0, 0, "R2");
    cyc(2'b00, 1, 16'hFF00, 1, 0, 0, "R8");
    // spare code behaves as hold (mode change flushes first)
    cyc(2'b11, 1, 16'h5555, 0, 0, 0, "R11");
    cyc(2'b11, 1, 16'h5555, 0, 0, 0, "R2");
    // R6 replace mode
    cyc(2'b01, 1, 16'h1111, 0, 0, 0, "R11");
    cyc(2'b01, 1, 16'h2222, 0, 0, 0, "R6");
    cyc(2'b01, 1, 16'h3333, 0, 0, 1, "R6");
    cyc(2'b01, 0, '0, 0, 0, 1, "R4");
    // R9 / R10 request mode
    cyc(2'b10, 0, '0, 0, 0, 0, "R11");
    cyc(2'b10, 1, 16'hDEAD, 0, 0, 0, "R9");
    cyc(2'b10, 0, '0, 0, 1, 0, "R10");
    cyc(2'b10, 1, 16'hBEEF, 0, 0, 0, "R10");
    cyc(2'b10, 0, '0, 0, 1, 0, "R10");
    // R11 flush with pending request and unread word
    cyc(2'b00, 0, '0, 0, 0, 0, "R11");
    // R12 all bits at once
    cyc(2'b00, 1, 16'hFFFF, 0, 0, 0, "R12");
    cyc(2'b00, 0, 16'h0000, 1, 0, 0, "R12");
    cyc(2'b00, 1, 16'h0000, 0, 0, 0, "R12");
    cyc(2'b00, 0, '0, 0, 0, 0, "R12");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] mv;
      string t;
      mv = (($urandom % 32) == 0) ? 2'($urandom) : m_mode;
      case (eff_mode(mv))
        1: t = "R6";
        2: t = "R10";
        default: t = "R2";
      endcase
      cyc(mv, ($urandom % 2) == 0, W'($urandom), ($urandom % 10) < 3,
          ($urandom % 5) == 0, ($urandom % 20) == 0, t);
    end
    cyc(m_mode, 0, '0, 0, 0, 0, "R12");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule